// File: doc/BRIEF.md
# Windowed Speculative/Committed Integer Register File

This block holds the integer registers of a processor core as two copies. A one-window working copy of 32 registers feeds the read ports and takes execution results as soon as they are computed. A committed copy holds every register of every window. It takes only retired results, written at the end of the pipeline once no exception can still cancel them. The working copy is what the pipeline reads. The committed copy is the state that survives a flush.

When an exception is signalled, the whole working copy is overwritten in a single cycle from the committed view of the current window, which discards every uncommitted result. When the window pointer moves (a decrement request for a call-side window shift, an increment request for the return side), the locals and ins of the newly selected window are loaded into the working copy in the same cycle. Globals and outs keep their working values. Each window's outs are the same committed storage as the ins of the window one below it, modulo the window count.

Top module: `win_regfile`

## Requirements
- R1: Register 0 always reads as zero. A speculative or committed write addressed to register 0 changes nothing.
- R2: Register numbering is fixed: 0-7 are globals shared by all windows, 8-15 are outs, 16-23 are locals and 24-31 are ins. The outs of window w are the same committed storage as the ins of window (w-1) mod NWIN.
- R3: A speculative write changes only the working copy. After an exception restore, the register shows its committed value again.
- R4: A committed write names a window and a register. It changes only the committed copy and is not visible on the read ports until a restore or refill brings it in.
- R5: Reads are registered with one cycle of latency. The data returned in cycle t+1 for an address presented in cycle t is the working contents after every update of cycle t, so a same-cycle speculative write is returned.
- R6: When two write ports of the same kind target the same register in one cycle, the higher-numbered port wins.
- R7: An exception restore overwrites registers 1-31 of the working copy from the committed view of the current window. That view includes committed writes made in the same cycle. Speculative writes of that cycle are lost, the window pointer is unchanged, and window requests in that cycle are ignored.
- R8: The window pointer resets to 0. A decrement request alone lowers it by one and an increment request alone raises it by one, both modulo NWIN. Both together leave it unchanged and start no refill.
- R9: A window change loads working registers 16-31 from the committed copy of the new window, including same-cycle committed writes. Speculative writes of that cycle to 16-31 are lost, and those to 1-15 take effect.
- R10: Synchronous reset clears both copies, the window pointer and the read data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr | input | NRD*5 | Read addresses, port p at bits [5p+4:5p] |
| rd_data | output | NRD*XLEN | Registered read data, port p at bits [XLEN*p+XLEN-1:XLEN*p] |
| sw_en | input | NSW | Speculative write enables |
| sw_addr | input | NSW*5 | Speculative write register numbers |
| sw_data | input | NSW*XLEN | Speculative write data |
| cw_en | input | NCW | Committed write enables |
| cw_win | input | NCW*WIN_W | Window of each committed write |
| cw_addr | input | NCW*5 | Committed write register numbers |
| cw_data | input | NCW*XLEN | Committed write data |
| win_dec_req | input | 1 | Move the window pointer down by one |
| win_inc_req | input | 1 | Move the window pointer up by one |
| exc_restore | input | 1 | Restore the working copy from the committed copy |
| cwp | output | WIN_W | Current window pointer |

## Verification
The bench builds the block with its defaults: 64-bit data, eight windows, two read ports, two speculative write ports and two committed write ports. With two ports of each write kind, same-cycle collisions and their priority can be reached. With eight windows, pointer wrap in both directions and the aliasing of outs onto the ins of window 7 from window 0 are reachable within a few cycles. Random runs mix exceptions and window changes with writes on both sides, so restore and refill often meet same-cycle commits and speculative writes.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int NREG = 32;
  localparam int RA_W = 5;
  localparam int GRP  = 8;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  function automatic reg_grp_e grp_of(input logic [RA_W-1:0] r);
    return reg_grp_e'(r[4:3]);
  endfunction
endpackage

// File: rtl/wrf_win_ptr.sv
module wrf_win_ptr #(
  parameter int NWIN = 8,
  localparam int WIN_W = $clog2(NWIN)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_req,
  input  logic             inc_req,
  input  logic             exc,
  output logic [WIN_W-1:0] cwp_q,
  output logic [WIN_W-1:0] cwp_nxt,
  output logic             refill
);
  logic [WIN_W-1:0] cwp_dn, cwp_up;

  assign cwp_dn = (cwp_q == '0) ? WIN_W'(NWIN - 1) : cwp_q - 1'b1;
  assign cwp_up = (cwp_q == WIN_W'(NWIN - 1)) ? '0 : cwp_q + 1'b1;
  assign refill = !exc && (dec_req ^ inc_req);

  always_comb begin
    cwp_nxt = cwp_q;
    if (refill) cwp_nxt = dec_req ? cwp_dn : cwp_up;
  end

  always_ff @(posedge clk) begin
    if (rst) cwp_q <= '0;
    else     cwp_q <= cwp_nxt;
  end
endmodule

// File: rtl/wrf_arch_store.sv
module wrf_arch_store
  import wrf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NWIN = 8,
  parameter int NCW  = 2,
  localparam int WIN_W    = $clog2(NWIN),
  localparam int WIN_SPAN = 2 * GRP,
  localparam int NPHYS    = GRP + NWIN * WIN_SPAN,
  localparam int PIDX_W   = $clog2(NPHYS)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             cw_en   [NCW],
  input  logic [WIN_W-1:0] cw_win  [NCW],
  input  logic [RA_W-1:0]  cw_addr [NCW],
  input  logic [XLEN-1:0]  cw_data [NCW],
  input  logic [WIN_W-1:0] view_win,
  output logic [XLEN-1:0]  view    [NREG]
);
  logic [XLEN-1:0] mem_q [NPHYS];
  logic [XLEN-1:0] mem_nxt [NPHYS];

  function automatic logic [PIDX_W-1:0] phys_idx(input logic [WIN_W-1:0] w,
                                                 input logic [RA_W-1:0]  r);
    logic [WIN_W-1:0] wb;
    int k;
    wb = (w == '0) ? WIN_W'(NWIN - 1) : w - 1'b1;
    k  = int'(r[2:0]);
    unique case (grp_of(r))
      GRP_GLOBAL: return PIDX_W'(k);
      GRP_OUT:    return PIDX_W'(GRP + int'(wb) * WIN_SPAN + GRP + k);
      GRP_LOCAL:  return PIDX_W'(GRP + int'(w) * WIN_SPAN + k);
      default:    return PIDX_W'(GRP + int'(w) * WIN_SPAN + GRP + k);
    endcase
  endfunction

  always_comb begin
    mem_nxt = mem_q;
    for (int p = 0; p < NCW; p++) begin
      if (cw_en[p] && cw_addr[p] != '0)
        mem_nxt[phys_idx(cw_win[p], cw_addr[p])] = cw_data[p];
    end
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      if (r == 0) view[r] = '0;
      else        view[r] = mem_nxt[phys_idx(view_win, RA_W'(r))];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
    end else begin
      mem_q <= mem_nxt;
    end
  end
endmodule

// File: rtl/wrf_work_file.sv
module wrf_work_file
  import wrf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NSW  = 2
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_en   [NSW],
  input  logic [RA_W-1:0] sw_addr [NSW],
  input  logic [XLEN-1:0] sw_data [NSW],
  input  logic            exc,
  input  logic            refill,
  input  logic [XLEN-1:0] view    [NREG],
  output logic [XLEN-1:0] wrk_q   [NREG],
  output logic [XLEN-1:0] wrk_nxt [NREG]
);
  always_comb begin
    wrk_nxt = wrk_q;
    for (int p = 0; p < NSW; p++) begin
      if (sw_en[p] && sw_addr[p] != '0) wrk_nxt[sw_addr[p]] = sw_data[p];
    end
    for (int r = 1; r < NREG; r++) begin
      if (exc) begin
        wrk_nxt[r] = view[r];
      end else if (refill && (grp_of(RA_W'(r)) == GRP_LOCAL ||
                              grp_of(RA_W'(r)) == GRP_IN)) begin
        wrk_nxt[r] = view[r];
      end
    end
    wrk_nxt[0] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) wrk_q[i] <= '0;
    end else begin
      wrk_q <= wrk_nxt;
    end
  end
endmodule

// File: rtl/wrf_read_port.sv
module wrf_read_port
  import wrf_pkg::*;
#(
  parameter int XLEN = 64
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] addr,
  input  logic [XLEN-1:0] src [NREG],
  output logic [XLEN-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= src[addr];
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NWIN = 8,
  parameter int NRD  = 2,
  parameter int NSW  = 2,
  parameter int NCW  = 2,
  localparam int WIN_W = $clog2(NWIN)
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NRD*RA_W-1:0]   rd_addr,
  output logic [NRD*XLEN-1:0]   rd_data,
  input  logic [NSW-1:0]        sw_en,
  input  logic [NSW*RA_W-1:0]   sw_addr,
  input  logic [NSW*XLEN-1:0]   sw_data,
  input  logic [NCW-1:0]        cw_en,
  input  logic [NCW*WIN_W-1:0]  cw_win,
  input  logic [NCW*RA_W-1:0]   cw_addr,
  input  logic [NCW*XLEN-1:0]   cw_data,
  input  logic                  win_dec_req,
  input  logic                  win_inc_req,
  input  logic                  exc_restore,
  output logic [WIN_W-1:0]      cwp
);
  logic            sw_en_a   [NSW];
  logic [RA_W-1:0] sw_addr_a [NSW];
  logic [XLEN-1:0] sw_data_a [NSW];
  logic             cw_en_a   [NCW];
  logic [WIN_W-1:0] cw_win_a  [NCW];
  logic [RA_W-1:0]  cw_addr_a [NCW];
  logic [XLEN-1:0]  cw_data_a [NCW];

  logic [WIN_W-1:0] cwp_q, cwp_nxt;
  logic             refill;
  logic [XLEN-1:0]  view    [NREG];
  logic [XLEN-1:0]  wrk_q   [NREG];
  logic [XLEN-1:0]  wrk_nxt [NREG];

  for (genvar p = 0; p < NSW; p++) begin : g_sw
    assign sw_en_a[p]   = sw_en[p];
    assign sw_addr_a[p] = sw_addr[p*RA_W +: RA_W];
    assign sw_data_a[p] = sw_data[p*XLEN +: XLEN];
  end

  for (genvar p = 0; p < NCW; p++) begin : g_cw
    assign cw_en_a[p]   = cw_en[p];
    assign cw_win_a[p]  = cw_win[p*WIN_W +: WIN_W];
    assign cw_addr_a[p] = cw_addr[p*RA_W +: RA_W];
    assign cw_data_a[p] = cw_data[p*XLEN +: XLEN];
  end

  wrf_win_ptr #(.NWIN(NWIN)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .dec_req (win_dec_req),
    .inc_req (win_inc_req),
    .exc     (exc_restore),
    .cwp_q   (cwp_q),
    .cwp_nxt (cwp_nxt),
    .refill  (refill)
  );

  wrf_arch_store #(.XLEN(XLEN), .NWIN(NWIN), .NCW(NCW)) u_arch (
    .clk      (clk),
    .rst      (rst),
    .cw_en    (cw_en_a),
    .cw_win   (cw_win_a),
    .cw_addr  (cw_addr_a),
    .cw_data  (cw_data_a),
    .view_win (cwp_nxt),
    .view     (view)
  );

  wrf_work_file #(.XLEN(XLEN), .NSW(NSW)) u_work (
    .clk     (clk),
    .rst     (rst),
    .sw_en   (sw_en_a),
    .sw_addr (sw_addr_a),
    .sw_data (sw_data_a),
    .exc     (exc_restore),
    .refill  (refill),
    .view    (view),
    .wrk_q   (wrk_q),
    .wrk_nxt (wrk_nxt)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    wrf_read_port #(.XLEN(XLEN)) u_rp (
      .clk    (clk),
      .rst    (rst),
      .addr   (rd_addr[p*RA_W +: RA_W]),
      .src    (wrk_nxt),
      .data_q (rd_data[p*XLEN +: XLEN])
    );
  end

  assign cwp = cwp_q;
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk
  import wrf_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NWIN = 8,
  parameter int NRD  = 2,
  parameter int NSW  = 2,
  localparam int WIN_W = $clog2(NWIN),
  localparam int TOP   = NSW - 1
)(
  input logic                clk,
  input logic                rst,
  input logic [NRD*RA_W-1:0] rd_addr,
  input logic [NRD*XLEN-1:0] rd_data,
  input logic [NSW-1:0]      sw_en,
  input logic [NSW*RA_W-1:0] sw_addr,
  input logic [NSW*XLEN-1:0] sw_data,
  input logic                dec_req,
  input logic                inc_req,
  input logic                exc,
  input logic [WIN_W-1:0]    cwp,
  input logic                refill,
  input logic [XLEN-1:0]     wrk_q [NREG],
  input logic [XLEN-1:0]     view  [NREG]
);
  // R1: register 0 returns zero on every read port
  for (genvar p = 0; p < NRD; p++) begin : g_zero
    p_zero_read_r1: assert property (@(posedge clk) disable iff (rst)
      rd_addr[p*RA_W +: RA_W] == '0 |=> rd_data[p*XLEN +: XLEN] == '0);
  end

  // R5/R6: highest speculative port is returned in the next cycle
  p_write_through_r5: assert property (@(posedge clk) disable iff (rst)
    (sw_en[TOP] && sw_addr[TOP*RA_W +: RA_W] != '0 &&
     rd_addr[RA_W-1:0] == sw_addr[TOP*RA_W +: RA_W] && !exc &&
     !(refill && sw_addr[TOP*RA_W + 4]))
    |=> rd_data[XLEN-1:0] == $past(sw_data[TOP*XLEN +: XLEN]));

  // R7: broadside copy from the committed view
  for (genvar r = 1; r < NREG; r++) begin : g_exc
    p_exc_copy_r7: assert property (@(posedge clk) disable iff (rst)
      exc |=> wrk_q[r] == $past(view[r]));
  end

  p_exc_keeps_cwp_r7: assert property (@(posedge clk) disable iff (rst)
    exc |=> $stable(cwp));

  // R9: locals and ins refilled on a window change
  for (genvar r = 2 * GRP; r < NREG; r++) begin : g_ref
    p_refill_copy_r9: assert property (@(posedge clk) disable iff (rst)
      refill |=> wrk_q[r] == $past(view[r]));
  end

  // R8: pointer movement
  p_dec_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_req && !inc_req && !exc) |=>
      (($past(cwp) == '0) ? (cwp == WIN_W'(NWIN - 1)) : (cwp == $past(cwp) - 1'b1)));

  p_inc_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (inc_req && !dec_req && !exc) |=>
      (($past(cwp) == WIN_W'(NWIN - 1)) ? (cwp == '0) : (cwp == $past(cwp) + 1'b1)));

  p_both_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (inc_req && dec_req) |=> $stable(cwp));
endmodule

bind win_regfile win_regfile_chk #(
  .XLEN(XLEN), .NWIN(NWIN), .NRD(NRD), .NSW(NSW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .sw_en   (sw_en),
  .sw_addr (sw_addr),
  .sw_data (sw_data),
  .dec_req (win_dec_req),
  .inc_req (win_inc_req),
  .exc     (exc_restore),
  .cwp     (cwp),
  .refill  (refill),
  .wrk_q   (wrk_q),
  .view    (view)
);

// File: tb/win_regfile_bench.sv
module win_regfile_bench;
  localparam int XLEN = 64;
  localparam int NWIN = 8;
  localparam int NRD  = 2;
  localparam int NSW  = 2;
  localparam int NCW  = 2;
  localparam int WIN_W = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NRD-1:0][4:0]       rd_addr;
  logic [NRD-1:0][XLEN-1:0]  rd_data;
  logic [NSW-1:0]            sw_en;
  logic [NSW-1:0][4:0]       sw_addr;
  logic [NSW-1:0][XLEN-1:0]  sw_data;
  logic [NCW-1:0]            cw_en;
  logic [NCW-1:0][WIN_W-1:0] cw_win;
  logic [NCW-1:0][4:0]       cw_addr;
  logic [NCW-1:0][XLEN-1:0]  cw_data;
  logic win_dec, win_inc, exc;
  logic [WIN_W-1:0] cwp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [XLEN-1:0] m_glob [8];
  logic [XLEN-1:0] m_loc  [NWIN][8];
  logic [XLEN-1:0] m_in   [NWIN][8];
  logic [XLEN-1:0] m_wk   [32];
  logic [XLEN-1:0] exp_rd [NRD];
  int m_cwp;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_regfile #(.XLEN(XLEN), .NWIN(NWIN), .NRD(NRD), .NSW(NSW), .NCW(NCW)) u_win_regfile (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
    .sw_en(sw_en), .sw_addr(sw_addr), .sw_data(sw_data),
    .cw_en(cw_en), .cw_win(cw_win), .cw_addr(cw_addr), .cw_data(cw_data),
    .win_dec_req(win_dec), .win_inc_req(win_inc), .exc_restore(exc), .cwp(cwp)
  );

  function automatic logic [XLEN-1:0] arch_rd(int w, int r);
    case (r / 8)
      0:       return (r == 0) ? '0 : m_glob[r % 8];
      1:       return m_in[(w + NWIN - 1) % NWIN][r % 8];
      2:       return m_loc[w][r % 8];
      default: return m_in[w][r % 8];
    endcase
  endfunction

  task automatic arch_wr(int w, int r, logic [XLEN-1:0] d);
    case (r / 8)
      0:       m_glob[r % 8] = d;
      1:       m_in[(w + NWIN - 1) % NWIN][r % 8] = d;
      2:       m_loc[w][r % 8] = d;
      default: m_in[w][r % 8] = d;
    endcase
  endtask

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sw_en = '0; cw_en = '0; win_dec = 1'b0; win_inc = 1'b0; exc = 1'b0;
  endtask

  task automatic model_step();
    logic [XLEN-1:0] nw [32];
    for (int p = 0; p < NCW; p++)
      if (cw_en[p] && cw_addr[p] != 0) arch_wr(int'(cw_win[p]), int'(cw_addr[p]), cw_data[p]);
    nw = m_wk;
    for (int p = 0; p < NSW; p++)
      if (sw_en[p] && sw_addr[p] != 0) nw[sw_addr[p]] = sw_data[p];
    if (exc) begin
      for (int r = 1; r < 32; r++) nw[r] = arch_rd(m_cwp, r);
    end else if (win_dec != win_inc) begin
      m_cwp = win_dec ? (m_cwp + NWIN - 1) % NWIN : (m_cwp + 1) % NWIN;
      for (int r = 16; r < 32; r++) nw[r] = arch_rd(m_cwp, r);
    end
    m_wk = nw;
    for (int p = 0; p < NRD; p++) exp_rd[p] = m_wk[rd_addr[p]];
  endtask

  // called at a negedge with stimulus already set
  task automatic cycle(string tag);
    model_step();
    @(negedge clk);
    for (int p = 0; p < NRD; p++) chk(tag, rd_data[p], exp_rd[p]);
    chk("R8", XLEN'(cwp), XLEN'(m_cwp));
    idle();
  endtask

  task automatic rd2(int a, int b);
    rd_addr[0] = 5'(a); rd_addr[1] = 5'(b);
  endtask

  task automatic spec(int p, int a, logic [XLEN-1:0] d);
    sw_en[p] = 1'b1; sw_addr[p] = 5'(a); sw_data[p] = d;
  endtask

  task automatic cmt(int p, int w, int a, logic [XLEN-1:0] d);
    cw_en[p] = 1'b1; cw_win[p] = WIN_W'(w); cw_addr[p] = 5'(a); cw_data[p] = d;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_glob[i] = '0;
    for (int w = 0; w < NWIN; w++)
      for (int i = 0; i < 8; i++) begin m_loc[w][i] = '0; m_in[w][i] = '0; end
    for (int i = 0; i < 32; i++) m_wk[i] = '0;
    m_cwp = 0;
    rd_addr = '0; sw_addr = '0; sw_data = '0; cw_win = '0; cw_addr = '0; cw_data = '0;
    idle();
    void'($urandom(32'd24681));

    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", rd_data[0], '0);
    chk("R10", rd_data[1], '0);
    chk("R10", XLEN'(cwp), '0);
    rst = 1'b0;
    for (int r = 0; r < 32; r += 2) begin rd2(r, r + 1); cycle("R10"); end

    // R1: register 0 writes discarded
    spec(0, 0, 64'hFFFF_0000_1234_5678); spec(1, 0, 64'h1); rd2(0, 0); cycle("R1");
    cmt(0, 0, 0, 64'hDEAD); cycle("R1");
    exc = 1'b1; rd2(0, 1); cycle("R1");

    // R6: same register on both speculative ports, then both commit ports
    spec(0, 5, 64'hAAAA); spec(1, 5, 64'hBBBB); rd2(5, 4); cycle("R6");
    cmt(0, 0, 6, 64'h1111); cmt(1, 0, 6, 64'h2222); cycle("R6");
    exc = 1'b1; rd2(6, 5); cycle("R6");

    // R5: write-through on the same cycle
    spec(1, 9, 64'h0909_0909); rd2(9, 9); cycle("R5");

    // R3: speculative only, then restore brings committed value back
    spec(0, 20, 64'hABCD_0020); rd2(20, 0); cycle("R3");
    exc = 1'b1; rd2(20, 9); cycle("R3");

    // R4: commit not visible until restore
    cmt(0, 0, 12, 64'h0C0C); rd2(12, 12); cycle("R4");
    rd2(12, 0); cycle("R4");
    exc = 1'b1; rd2(12, 0); cycle("R4");

    // R2: ins of window NWIN-1 are the outs of window 0
    cmt(0, NWIN - 1, 27, 64'h2727_0000); cmt(1, 3, 2, 64'h0202); cycle("R2");
    exc = 1'b1; rd2(11, 2); cycle("R2");

    // R7: commit, speculative write and window request together with restore
    cmt(0, 0, 18, 64'h1818); spec(0, 18, 64'hBAD0); spec(1, 3, 64'hBAD1);
    win_dec = 1'b1; exc = 1'b1; rd2(18, 3); cycle("R7");

    // R8: both requests together, then wrap both ways
    win_dec = 1'b1; win_inc = 1'b1; rd2(18, 20); cycle("R8");
    win_dec = 1'b1; rd2(16, 24); cycle("R8");
    win_inc = 1'b1; rd2(18, 27); cycle("R8");

    // R9: refill with same-cycle commit into the new window and speculative writes
    cmt(0, NWIN - 1, 22, 64'h2222_0007); cmt(1, NWIN - 1, 9, 64'h0909_0007);
    spec(0, 4, 64'h0404); spec(1, 22, 64'hBAD2);
    win_dec = 1'b1; rd2(22, 4); cycle("R9");
    rd2(9, 27); cycle("R9");
    win_inc = 1'b1; rd2(11, 18); cycle("R9");

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NRD; p++) rd_addr[p] = 5'($urandom_range(0, 31));
      for (int p = 0; p < NSW; p++) begin
        sw_en[p] = ($urandom_range(0, 1) == 1);
        sw_addr[p] = ($urandom_range(0, 1) == 1) ? 5'($urandom_range(0, 31)) : 5'($urandom_range(16, 19));
        sw_data[p] = {$urandom(), $urandom()};
      end
      for (int p = 0; p < NCW; p++) begin
        cw_en[p] = ($urandom_range(0, 1) == 1);
        cw_win[p] = WIN_W'($urandom_range(0, NWIN - 1));
        cw_addr[p] = 5'($urandom_range(0, 31));
        cw_data[p] = {$urandom(), $urandom()};
      end
      exc = ($urandom_range(0, 19) == 0);
      win_dec = ($urandom_range(0, 9) == 0);
      win_inc = ($urandom_range(0, 9) == 0);
      cycle("R5");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10: actual run still busy, expected completion before watchdog");
      summary();
      $finish;
    end
  end
endmodule